// File: doc/BRIEF.md
# JTAG Nibble Command Engine

This block turns a stream of bytes into activity on a JTAG test access port. Each byte holds two 4-bit commands, and the engine runs them one at a time. A command can do nothing, clock one TCK cycle with chosen TMS and TDI levels, or clock one cycle and then compare TDO with an expected level. Any TDO mismatch sets a sticky error flag, which the host reads and clears.

A two-nibble escape loads a 4-bit sync value. The host polls this value to learn how far the stream has been executed. The TCK low and high phases are stretched by a loadable timing value. A host reset forces the target TAP into Test-Logic-Reset with sixteen TMS-high pulses, and it restores the default state of the engine.

Top module: `jne_engine`

## Requirements
- R1: Each accepted byte runs as two commands: bits [3:0] first, then bits [7:4].
- R2: Command 0000 does nothing. Commands 0010 and 0011 are reserved. None of these three changes TCK, TMS, TDI, the error flag or the sync value.
- R3: Command 0001 is an escape. The nibble that follows it is loaded into `sync_val` and is not run as a command. This also applies when the escape is the high nibble and the loaded nibble is the low nibble of the next byte.
- R4: A command 01ab gives one TCK cycle with TMS=a and TDI=b. It never touches the error flag, whatever TDO is.
- R5: A command 1cab gives one TCK cycle with TMS=a and TDI=b. On the last clock of the TCK high phase, TDO is compared with c, and a mismatch sets `err_flag`.
- R6: `err_flag` stays set until `clr_err`, `host_rst` or `rst_n` clears it. When a clear and a mismatch fall in the same clock, the clear wins.
- R7: TCK idles high. Each TCK cycle is one clock of setup with TCK high, then T+1 clocks low, then T+1 clocks high. TMS and TDI change only while TCK is high.
- R8: A `tim_load` pulse stores `tim_val` as T. The new value applies from the next TCK cycle that starts.
- R9: After `rst_n` or a `host_rst` pulse, the engine gives sixteen TCK cycles with TMS=1, TDI=1 and T=0. It clears the error flag, the sync value, T and a pending escape. No byte is accepted until this sequence ends.
- R10: A `clr_sync` pulse sets `sync_val` to 0, and it wins over a sync load in the same clock.
- R11: `in_ready` is high only while the engine is idle, and `busy` is its complement. A byte is taken in a clock where `in_valid` and `in_ready` are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_rst | input | 1 | Pulse: abort and run the TAP reset sequence |
| in_data | input | 8 | Command byte (two nibbles) |
| in_valid | input | 1 | `in_data` is valid |
| in_ready | output | 1 | Engine accepts a byte this clock |
| tim_val | input | TIM_W | TCK phase stretch value |
| tim_load | input | 1 | Pulse: store `tim_val` |
| clr_err | input | 1 | Pulse: clear error flag |
| clr_sync | input | 1 | Pulse: clear sync value |
| tck | output | 1 | TAP clock |
| tms | output | 1 | TAP mode select |
| tdi | output | 1 | TAP data to target |
| tdo | input | 1 | TAP data from target |
| err_flag | output | 1 | Sticky TDO mismatch flag |
| sync_val | output | 4 | Last sync value loaded by escape |
| busy | output | 1 | Engine is working |

## Verification
The hardest case to reach from the ports is an escape whose operand lies in the next byte. Here the pending escape must survive the return to idle and the next handshake. The stimulus sends a byte with a no-op low nibble and an escape high nibble, then a byte whose low nibble must land in `sync_val` and whose high nibble must still produce a TCK pulse. The same pending-escape case is then set up just before a host reset, to show that the reset drops it. A scoreboard predicts every TCK pulse, with its TMS, TDI and low-phase width, from a software model of the nibble rules. Any extra, missing or misshapen pulse is reported.

// File: rtl/jne_pkg.sv
// Shared types for the JTAG nibble command engine.
package jne_pkg;

    // Class of a decoded 4-bit command
    typedef enum logic [2:0] {
        NK_NOP,
        NK_ESCAPE,
        NK_RESERVED,
        NK_DRIVE,
        NK_COMPARE
    } nib_kind_t;

    // Decoded command fields
    typedef struct packed {
        nib_kind_t kind;
        logic      tms;
        logic      tdi;
        logic      exp_tdo;
    } nib_cmd_t;

    // Phases of one TCK cycle
    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SETUP,
        PH_LOW,
        PH_HIGH
    } tck_phase_t;

    // Top-level sequencer states
    typedef enum logic [2:0] {
        SQ_RST_GO,
        SQ_RST_WAIT,
        SQ_IDLE,
        SQ_DECODE,
        SQ_PULSE
    } seq_state_t;

endpackage

// File: rtl/jne_decode.sv
// Nibble decoder: classifies one 4-bit command and extracts its pin levels.
// Assumes: purely combinational; escape operand handling lives in the sequencer.
module jne_decode
    import jne_pkg::*;
(
    input  logic [3:0] nib,
    output nib_cmd_t   cmd
);

    // Map nibble patterns onto command classes
    always_comb begin
        cmd.tms     = nib[1];
        cmd.tdi     = nib[0];
        cmd.exp_tdo = nib[2];
        casez (nib)
            4'b0000: cmd.kind = NK_NOP;
            4'b0001: cmd.kind = NK_ESCAPE;
            4'b001?: cmd.kind = NK_RESERVED;
            4'b01??: cmd.kind = NK_DRIVE;
            default: cmd.kind = NK_COMPARE;
        endcase
    end

endmodule

// File: rtl/jne_tck_gen.sv
// TCK cycle generator: one setup clock with TCK high, then STRETCH+1 clocks low
// and STRETCH+1 clocks high. Pin levels and stretch are latched at start.
// Assumes: start is only raised while the generator is idle; abort returns it
// to idle with TCK high in one clock.
module jne_tck_gen
    import jne_pkg::*;
#(
    parameter int STRETCH_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 abort,
    input  logic                 start,
    input  logic                 tms_in,
    input  logic                 tdi_in,
    input  logic [STRETCH_W-1:0] stretch,
    output logic                 tck,
    output logic                 tms,
    output logic                 tdi,
    output logic                 done
);

    tck_phase_t           phase_q;
    logic [STRETCH_W-1:0] cnt_q;
    logic [STRETCH_W-1:0] len_q;
    logic                 tms_q;
    logic                 tdi_q;

    // Phase sequencing and pin latching
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            len_q   <= '0;
            tms_q   <= 1'b1;
            tdi_q   <= 1'b1;
        end else if (abort) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: begin
                    if (start) begin
                        tms_q   <= tms_in;
                        tdi_q   <= tdi_in;
                        len_q   <= stretch;
                        cnt_q   <= '0;
                        phase_q <= PH_SETUP;
                    end
                end
                PH_SETUP: begin
                    cnt_q   <= '0;
                    phase_q <= PH_LOW;
                end
                PH_LOW: begin
                    if (cnt_q == len_q) begin
                        cnt_q   <= '0;
                        phase_q <= PH_HIGH;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                default: begin
                    if (cnt_q == len_q) begin
                        cnt_q   <= '0;
                        phase_q <= PH_IDLE;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
            endcase
        end
    end

    assign tck  = (phase_q != PH_LOW);
    assign tms  = tms_q;
    assign tdi  = tdi_q;
    assign done = (phase_q == PH_HIGH) && (cnt_q == len_q);

endmodule

// File: rtl/jne_flags.sv
// Host-visible flags: sticky TDO error and sync value.
// Assumes: clears take priority over sets in the same clock.
module jne_flags #(
    parameter int SYNC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_rst,
    input  logic              clr_err,
    input  logic              clr_sync,
    input  logic              err_set,
    input  logic              sync_load,
    input  logic [SYNC_W-1:0] sync_din,
    output logic              err_flag,
    output logic [SYNC_W-1:0] sync_val
);

    // Sticky error bit
    always_ff @(posedge clk) begin
        if (!rst_n || host_rst) err_flag <= 1'b0;
        else if (clr_err)       err_flag <= 1'b0;
        else if (err_set)       err_flag <= 1'b1;
    end

    // Sync value register
    always_ff @(posedge clk) begin
        if (!rst_n || host_rst) sync_val <= '0;
        else if (clr_sync)      sync_val <= '0;
        else if (sync_load)     sync_val <= sync_din;
    end

endmodule

// File: rtl/jne_engine.sv
// JTAG nibble command engine top: accepts command bytes, runs the low nibble
// then the high nibble, drives TCK/TMS/TDI and checks TDO on compare commands.
// Assumes: rst_n is synchronous active-low; host_rst is a one-clock pulse that
// aborts any work and replays the TAP reset sequence.
module jne_engine
    import jne_pkg::*;
#(
    parameter int TIM_W      = 8,
    parameter int RST_PULSES = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_rst,
    input  logic [7:0]       in_data,
    input  logic             in_valid,
    output logic             in_ready,
    input  logic [TIM_W-1:0] tim_val,
    input  logic             tim_load,
    input  logic             clr_err,
    input  logic             clr_sync,
    output logic             tck,
    output logic             tms,
    output logic             tdi,
    input  logic             tdo,
    output logic             err_flag,
    output logic [3:0]       sync_val,
    output logic             busy
);

    localparam int RST_CNT_W = (RST_PULSES > 1) ? $clog2(RST_PULSES) : 1;
    localparam logic [RST_CNT_W-1:0] RST_LAST = RST_CNT_W'(RST_PULSES - 1);

    seq_state_t           state_q;
    logic [7:0]           byte_q;
    logic                 nib_hi_q;
    logic                 skip_q;
    logic                 chk_q;
    logic                 exp_q;
    logic [RST_CNT_W-1:0] rst_cnt_q;
    logic [TIM_W-1:0]     tim_q;

    logic [3:0]       cur_nib;
    nib_cmd_t         cmd;
    logic             drv_start;
    logic             drv_tms;
    logic             drv_tdi;
    logic             drv_done;
    logic [TIM_W-1:0] drv_stretch;
    logic             sync_load;
    logic             err_set;

    assign cur_nib = nib_hi_q ? byte_q[7:4] : byte_q[3:0];

    jne_decode u_decode (
        .nib (cur_nib),
        .cmd (cmd)
    );

    // Choose what the TCK generator and flag registers receive this clock
    always_comb begin
        drv_start   = 1'b0;
        drv_tms     = 1'b1;
        drv_tdi     = 1'b1;
        drv_stretch = tim_q;
        sync_load   = 1'b0;
        err_set     = 1'b0;
        case (state_q)
            SQ_RST_GO: begin
                drv_start   = 1'b1;
                drv_stretch = '0;
            end
            SQ_DECODE: begin
                if (skip_q) begin
                    sync_load = 1'b1;
                end else if (cmd.kind == NK_DRIVE || cmd.kind == NK_COMPARE) begin
                    drv_start = 1'b1;
                    drv_tms   = cmd.tms;
                    drv_tdi   = cmd.tdi;
                end
            end
            SQ_PULSE: begin
                err_set = drv_done && chk_q && (tdo != exp_q);
            end
            default: ;
        endcase
    end

    // Sequencer: reset pulses, byte intake and nibble stepping
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= SQ_RST_GO;
            byte_q    <= '0;
            nib_hi_q  <= 1'b0;
            skip_q    <= 1'b0;
            chk_q     <= 1'b0;
            exp_q     <= 1'b0;
            rst_cnt_q <= '0;
            tim_q     <= '0;
        end else if (host_rst) begin
            state_q   <= SQ_RST_GO;
            nib_hi_q  <= 1'b0;
            skip_q    <= 1'b0;
            rst_cnt_q <= '0;
            tim_q     <= '0;
        end else begin
            if (tim_load) tim_q <= tim_val;
            case (state_q)
                SQ_RST_GO: state_q <= SQ_RST_WAIT;
                SQ_RST_WAIT: begin
                    if (drv_done) begin
                        if (rst_cnt_q == RST_LAST) begin
                            state_q <= SQ_IDLE;
                        end else begin
                            rst_cnt_q <= rst_cnt_q + 1'b1;
                            state_q   <= SQ_RST_GO;
                        end
                    end
                end
                SQ_IDLE: begin
                    if (in_valid) begin
                        byte_q   <= in_data;
                        nib_hi_q <= 1'b0;
                        state_q  <= SQ_DECODE;
                    end
                end
                SQ_DECODE: begin
                    if (!skip_q && (cmd.kind == NK_DRIVE || cmd.kind == NK_COMPARE)) begin
                        chk_q   <= (cmd.kind == NK_COMPARE);
                        exp_q   <= cmd.exp_tdo;
                        state_q <= SQ_PULSE;
                    end else begin
                        skip_q   <= !skip_q && (cmd.kind == NK_ESCAPE);
                        nib_hi_q <= 1'b1;
                        state_q  <= nib_hi_q ? SQ_IDLE : SQ_DECODE;
                    end
                end
                default: begin
                    if (drv_done) begin
                        nib_hi_q <= 1'b1;
                        state_q  <= nib_hi_q ? SQ_IDLE : SQ_DECODE;
                    end
                end
            endcase
        end
    end

    jne_tck_gen #(
        .STRETCH_W (TIM_W)
    ) u_tck_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .abort   (host_rst),
        .start   (drv_start),
        .tms_in  (drv_tms),
        .tdi_in  (drv_tdi),
        .stretch (drv_stretch),
        .tck     (tck),
        .tms     (tms),
        .tdi     (tdi),
        .done    (drv_done)
    );

    jne_flags #(
        .SYNC_W (4)
    ) u_flags (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_rst  (host_rst),
        .clr_err   (clr_err),
        .clr_sync  (clr_sync),
        .err_set   (err_set),
        .sync_load (sync_load),
        .sync_din  (cur_nib),
        .err_flag  (err_flag),
        .sync_val  (sync_val)
    );

    assign in_ready = (state_q == SQ_IDLE) && !host_rst;
    assign busy     = (state_q != SQ_IDLE);

endmodule

// File: rtl/jne_checker.sv
// Temporal checks on the engine's ports, bound to every jne_engine instance.
module jne_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       host_rst,
    input logic       in_valid,
    input logic       in_ready,
    input logic       clr_err,
    input logic       clr_sync,
    input logic       tck,
    input logic       tms,
    input logic       tdi,
    input logic       err_flag,
    input logic [3:0] sync_val,
    input logic       busy
);

    a_r7_tck_high_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> tck);

    a_r7_pins_hold_while_low: assert property (@(posedge clk) disable iff (!rst_n)
        !tck |-> ($stable(tms) && $stable(tdi)));

    a_r7_fall_only_when_working: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tck) |-> busy);

    a_r6_error_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (err_flag && !clr_err && !host_rst) |=> err_flag);

    a_r11_accept_goes_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> busy);

    a_r3_sync_moves_only_when_working: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sync_val) |-> ($past(busy) || $past(clr_sync) || $past(host_rst)));

endmodule

bind jne_engine jne_checker u_jne_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .host_rst (host_rst),
    .in_valid (in_valid),
    .in_ready (in_ready),
    .clr_err  (clr_err),
    .clr_sync (clr_sync),
    .tck      (tck),
    .tms      (tms),
    .tdi      (tdi),
    .err_flag (err_flag),
    .sync_val (sync_val),
    .busy     (busy)
);

// File: tb/test_jne_engine.sv
// Scoreboard bench: stimulus tasks push predicted TCK pulses, a monitor pops
// and compares them as the engine produces them.
module test_jne_engine;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_rst = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_valid = 1'b0;
    logic       in_ready;
    logic [7:0] tim_val = '0;
    logic       tim_load = 1'b0;
    logic       clr_err = 1'b0;
    logic       clr_sync = 1'b0;
    logic       tck, tms, tdi;
    logic       tdo = 1'b0;
    logic       err_flag;
    logic [3:0] sync_val;
    logic       busy;

    always #10 clk = ~clk;

    jne_engine i_jne_engine (
        .clk(clk), .rst_n(rst_n), .host_rst(host_rst),
        .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
        .tim_val(tim_val), .tim_load(tim_load),
        .clr_err(clr_err), .clr_sync(clr_sync),
        .tck(tck), .tms(tms), .tdi(tdi), .tdo(tdo),
        .err_flag(err_flag), .sync_val(sync_val), .busy(busy)
    );

    int n_checks = 0;
    int n_err = 0;
    int cyc = 0;

    int   q_pins[$];
    int   q_width[$];
    bit   m_skip = 0;
    bit   m_err = 0;
    logic [3:0] m_sync = '0;
    int   m_tim = 0;

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Monitor: pop one prediction per observed TCK rising edge
    logic prev_tck = 1'b1;
    int   lowcnt = 0;
    always @(negedge clk) begin
        if (tck === 1'b0) begin
            lowcnt++;
        end else begin
            if (prev_tck === 1'b0) begin
                if (q_pins.size() == 0) begin
                    check(0, "R7 unexpected TCK pulse", 1, 0);
                end else begin
                    int ep, ew;
                    ep = q_pins.pop_front();
                    ew = q_width.pop_front();
                    check({tms, tdi} == 2'(ep), "R1/R4 pulse TMS,TDI", int'({tms, tdi}), ep);
                    check(lowcnt == ew, "R7 TCK low width", lowcnt, ew);
                end
            end
            lowcnt = 0;
        end
        prev_tck = tck;
    end

    // Watchdog
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_checks++;
            n_err++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 100000);
            $display("Result: errors=%0d of %0d checks", n_err, n_checks);
            $finish;
        end
    end

    task automatic model_nib(input logic [3:0] n);
        if (m_skip) begin
            m_sync = n;
            m_skip = 0;
        end else if (n == 4'h0) begin
        end else if (n == 4'h1) begin
            m_skip = 1;
        end else if (n[3:1] == 3'b001) begin
        end else begin
            q_pins.push_back(int'(n[1:0]));
            q_width.push_back(m_tim + 1);
            if (n[3] && (n[2] != tdo)) m_err = 1;
        end
    endtask

    task automatic push_reset_seq();
        for (int i = 0; i < 16; i++) begin
            q_pins.push_back(3);
            q_width.push_back(1);
        end
        m_err = 0; m_sync = '0; m_skip = 0; m_tim = 0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic send_byte(input logic [7:0] b);
        model_nib(b[3:0]);
        model_nib(b[7:4]);
        @(negedge clk);
        in_data  = b;
        in_valid = 1'b1;
        while (!in_ready) @(negedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        check(!in_ready && busy, "R11 not ready while working", int'(in_ready), 0);
        wait_idle();
    endtask

    task automatic check_flags(input string tag);
        check(err_flag == m_err, {tag, " err_flag"}, int'(err_flag), int'(m_err));
        check(sync_val == m_sync, {tag, " sync_val"}, int'(sync_val), int'(m_sync));
        check(q_pins.size() == 0, {tag, " all pulses seen"}, q_pins.size(), 0);
    endtask

    task automatic pulse_clr_err();
        @(negedge clk); clr_err = 1'b1;
        @(negedge clk); clr_err = 1'b0;
        m_err = 0;
    endtask

    task automatic load_tim(input int v);
        @(negedge clk); tim_val = 8'(v); tim_load = 1'b1;
        @(negedge clk); tim_load = 1'b0;
        m_tim = v;
    endtask

    initial begin
        // R9: power-on reset sequence
        push_reset_seq();
        repeat (5) @(negedge clk);
        check(tck == 1'b1, "R7 TCK high in reset", int'(tck), 1);
        rst_n = 1'b1;
        @(negedge clk);
        wait_idle();
        check_flags("R9 after reset");
        check(in_ready == 1'b1, "R11 ready when idle", int'(in_ready), 1);
        check(tck == 1'b1, "R7 TCK idles high", int'(tck), 1);

        // R1: low nibble first, then high nibble
        send_byte(8'h74);
        check_flags("R1 order");

        // R2: no-op and reserved nibbles leave everything alone
        send_byte(8'h00);
        check_flags("R2 nop");
        send_byte(8'h32);
        check_flags("R2 reserved");

        // R3: escape within a byte and across a byte boundary
        send_byte(8'h51);
        check_flags("R3 escape in byte");
        send_byte(8'h10);
        check(sync_val == 4'h5, "R3 sync held while escape pending", int'(sync_val), 5);
        send_byte(8'h4A);
        check_flags("R3 escape across bytes");

        // R4: drive command ignores TDO
        tdo = 1'b0;
        send_byte(8'h77);
        check_flags("R4 no check");

        // R5: compare commands
        tdo = 1'b1;
        send_byte(8'hCC);
        check_flags("R5 match z=1");
        tdo = 1'b0;
        send_byte(8'h4D);
        check_flags("R5 mismatch z=1");
        check(err_flag == 1'b1, "R5 error raised", int'(err_flag), 1);

        // R6: sticky until cleared
        send_byte(8'h44);
        check_flags("R6 sticky");
        pulse_clr_err();
        check(err_flag == 1'b0, "R6 cleared", int'(err_flag), 0);
        tdo = 1'b1;
        send_byte(8'h09);
        check_flags("R5 mismatch z=0");
        pulse_clr_err();

        // R8: stretched timing
        load_tim(3);
        send_byte(8'h45);
        check_flags("R8 stretched");
        load_tim(0);
        send_byte(8'h66);
        check_flags("R8 back to fastest");

        // R10: clear sync
        @(negedge clk); clr_sync = 1'b1;
        @(negedge clk); clr_sync = 1'b0;
        m_sync = '0;
        check(sync_val == 4'h0, "R10 sync cleared", int'(sync_val), 0);
        send_byte(8'h61);
        check_flags("R10 reload after clear");

        // R9: host reset clears error, sync, timing and pending escape
        load_tim(2);
        tdo = 1'b1;
        send_byte(8'h08);
        send_byte(8'h10);
        check_flags("R9 before host reset");
        push_reset_seq();
        @(negedge clk); host_rst = 1'b1;
        @(negedge clk); host_rst = 1'b0;
        wait_idle();
        check_flags("R9 after host reset");
        send_byte(8'h44);
        check_flags("R9 escape dropped and timing restored");

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_err, n_checks);
        $finish;
    end

endmodule